// File: doc/BRIEF.md
# Indexed Interrupt Enable Controller

This block gathers level-sensitive interrupt requests and steers them to up to four processors, driving one IRQ line per processor. Sources numbered 0 to 31 are private: each processor has its own 32 private inputs and its own mask bits for them. Sources from 32 upward are shared, and each has a single enable bit. Software never edits enable or mask vectors directly. It writes a source number to a set or clear register, and only that one source changes.

Each source also has a control word that picks which processors it is routed to. Each processor can read three things: its private pending levels, the number of its lowest-numbered deliverable source (an acknowledge read that changes no state), and a threshold register. While the threshold register holds zero, delivery is open. The register interface is a simple 32-bit bus with single-cycle access. One select bit chooses between the global window and the processor window. In the processor window, address bits [11:8] select the processor and bits [7:0] select the register.

Top module: `idx_intc`

## Requirements
- R1: After reset, all IRQ lines are low and the controller enable bit is 0. All shared enables are 0, all private mask bits are set (masked), all routing words are 0 and all thresholds are 0.
- R2: Global offset 0x000 reads the controller enable in bit 0 and the number of implemented sources in bits [11:2]. Only bit 0 is writable. Every other bit reads 0.
- R3: A write of index n to global offset 0x030 sets the enable of shared source n. A write to 0x034 clears it. Only wdata bits [9:0] form the index. Indices below 32 or not below the source count are ignored.
- R4: A write of index n (n < 32) to processor offset 0x048 masks private source n for that processor only. A write to 0x04C unmasks it. Indices of 32 or more are ignored.
- R5: The control word of source n lives at global offset 0x100 + 4n. Bit c routes the source to processor c. Only bits [NUM_CPU-1:0] are stored, and the other bits read 0.
- R6: irq_o[c] is high one cycle after all of the following hold: some source is pending, it is enabled (shared) or unmasked for c (private), it is routed to c, the controller enable is 1, and c's threshold is 0.
- R7: Processor offset 0x010 reads the current levels of that processor's 32 private inputs, one bit per source.
- R8: Processor offset 0x044 reads the lowest-numbered source that is deliverable to that processor under R6. It reads 0x3FF when there is none.
- R9: Processor offset 0x040 holds a 4-bit threshold. While it is non-zero, that processor's IRQ line stays low and its acknowledge read returns 0x3FF.
- R10: Read data appears on bus_rdata in the cycle after the read access and holds until the next read. Processor-window accesses to a processor number of NUM_CPU or more read 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_cpu_win | input | 1 | 1 = processor window, 0 = global window |
| bus_addr | input | 12 | Byte address within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_shared_i | input | NUM_SRC-32 | Levels of shared sources 32 and up |
| src_priv_i | input | NUM_CPU*32 | Private levels, processor c at bits [32c+31:32c] |
| irq_o | output | NUM_CPU | Registered IRQ line per processor |

## Verification
The properties assume the following about the inputs: every access lasts exactly one cycle, and bus_wr is meaningful only together with bus_sel. They also assume that source levels are ordinary synchronous signals that settle before the clock edge. The bench respects this. It changes every input on the falling edge, issues at most one access per cycle, and applies reset before any access. It samples irq_o and bus_rdata one falling edge after the rising edge that should update them.

// File: rtl/idx_intc_pkg.sv
package idx_intc_pkg;
   localparam int unsigned BUS_W    = 32;
   localparam int unsigned ADDR_W   = 12;
   localparam int unsigned IDX_W    = 10;
   localparam int unsigned PRIV_SRC = 32;
   localparam int unsigned PRIV_W   = 5;
   localparam int unsigned THR_W    = 4;
   localparam int unsigned MAX_CPU  = 4;
   localparam int unsigned MAX_SRC  = 960;
   localparam int unsigned CSEL_W   = ADDR_W - 8;

   localparam logic [IDX_W-1:0] NO_IRQ = 10'h3ff;

   // global window
   localparam logic [ADDR_W-1:0] G_CTRL      = 12'h000;
   localparam logic [ADDR_W-1:0] G_SET_EN    = 12'h030;
   localparam logic [ADDR_W-1:0] G_CLR_EN    = 12'h034;
   localparam logic [ADDR_W-1:0] G_WORD_BASE = 12'h100;

   // processor window, low byte of the address
   localparam logic [7:0] C_PEND   = 8'h10;
   localparam logic [7:0] C_THR    = 8'h40;
   localparam logic [7:0] C_ACK    = 8'h44;
   localparam logic [7:0] C_MASK   = 8'h48;
   localparam logic [7:0] C_UNMASK = 8'h4c;

   typedef struct packed {
      logic             mask_wr;
      logic             unmask_wr;
      logic             thr_wr;
      logic [IDX_W-1:0] idx;
      logic [THR_W-1:0] thr;
   } cpu_cmd_t;
endpackage

// File: rtl/idx_intc_lowest.sv
module idx_intc_lowest #(
   parameter  int unsigned N = 64,
   localparam int unsigned W = $clog2(N)
)(
   input  logic [N-1:0] vec,
   output logic         hit,
   output logic [W-1:0] pos
);
   always_comb begin
      hit = |vec;
      pos = '0;
      for (int i = int'(N) - 1; i >= 0; i--) begin
         if (vec[i]) pos = W'(i);
      end
   end
endmodule

// File: rtl/idx_intc_route_bank.sv
module idx_intc_route_bank
   import idx_intc_pkg::*;
#(
   parameter  int unsigned NUM_SRC = 64,
   parameter  int unsigned NUM_CPU = 4,
   localparam int unsigned SRC_W   = $clog2(NUM_SRC)
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              set_en,
   input  logic                              clr_en,
   input  logic [IDX_W-1:0]                  en_idx,
   input  logic                              word_wr,
   input  logic [SRC_W-1:0]                  word_idx,
   input  logic [NUM_CPU-1:0]                word_data,
   output logic [NUM_SRC-1:0]                en_o,
   output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_o
);
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [NUM_CPU-1:0] route_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   route_q <= '0;
         else if (word_wr && word_idx == SRC_W'(s))    route_q <= word_data;
      end
      assign route_o[s] = route_q;

      if (s < PRIV_SRC) begin : g_priv
         assign en_o[s] = 1'b0;
      end else begin : g_shared
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  en_q <= 1'b0;
            else if (set_en && en_idx == IDX_W'(s))      en_q <= 1'b1;
            else if (clr_en && en_idx == IDX_W'(s))      en_q <= 1'b0;
         end
         assign en_o[s] = en_q;
      end
   end
endmodule

// File: rtl/idx_intc_cpu_port.sv
module idx_intc_cpu_port
   import idx_intc_pkg::*;
#(
   parameter  int unsigned NUM_SRC = 64,
   localparam int unsigned SRC_W   = $clog2(NUM_SRC)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  cpu_cmd_t           cmd,
   input  logic               ctrl_en,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] en,
   input  logic [NUM_SRC-1:0] route_col,
   output logic               irq_o,
   output logic [IDX_W-1:0]   ack_id_o,
   output logic [THR_W-1:0]   thr_o,
   output logic               thr_zero_o
);
   logic [PRIV_SRC-1:0] mask_q;
   logic [THR_W-1:0]    thr_q;
   logic [NUM_SRC-1:0]  gate;
   logic [NUM_SRC-1:0]  elig;
   logic                hit;
   logic [SRC_W-1:0]    pos;
   logic                open;
   logic                unused_en;

   assign unused_en = ^en[PRIV_SRC-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         thr_q  <= '0;
      end else begin
         if (cmd.mask_wr && cmd.idx < IDX_W'(PRIV_SRC))
            mask_q[cmd.idx[PRIV_W-1:0]] <= 1'b1;
         else if (cmd.unmask_wr && cmd.idx < IDX_W'(PRIV_SRC))
            mask_q[cmd.idx[PRIV_W-1:0]] <= 1'b0;
         if (cmd.thr_wr) thr_q <= cmd.thr;
      end
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
      if (s < PRIV_SRC) begin : g_priv
         assign gate[s] = ~mask_q[s];
      end else begin : g_shared
         assign gate[s] = en[s];
      end
   end

   assign elig = pend & gate & route_col & {NUM_SRC{ctrl_en}};
   assign open = (thr_q == '0);

   idx_intc_lowest #(.N(NUM_SRC)) u_low (
      .vec (elig),
      .hit (hit),
      .pos (pos)
   );

   assign ack_id_o   = (hit && open) ? IDX_W'(pos) : NO_IRQ;
   assign thr_o      = thr_q;
   assign thr_zero_o = open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= hit && open;
   end
endmodule

// File: rtl/idx_intc.sv
module idx_intc
   import idx_intc_pkg::*;
#(
   parameter int unsigned NUM_CPU = 4,
   parameter int unsigned NUM_SRC = 64
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_sel,
   input  logic                        bus_wr,
   input  logic                        bus_cpu_win,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [BUS_W-1:0]            bus_wdata,
   output logic [BUS_W-1:0]            bus_rdata,
   input  logic [NUM_SRC-PRIV_SRC-1:0] src_shared_i,
   input  logic [NUM_CPU*PRIV_SRC-1:0] src_priv_i,
   output logic [NUM_CPU-1:0]          irq_o
);
   localparam int unsigned SRC_W    = $clog2(NUM_SRC);
   localparam int unsigned WORD_END = 32'h100 + 4 * NUM_SRC;

   if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu
      $error("idx_intc: NUM_CPU must be 1..4");
   end
   if (NUM_SRC <= PRIV_SRC || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("idx_intc: NUM_SRC must be 33..960");
   end

   logic                              wr_acc, rd_acc, g_wr;
   logic [IDX_W-1:0]                  wr_idx;
   logic                              word_hit;
   logic [SRC_W-1:0]                  word_idx;
   logic [CSEL_W-1:0]                 cpu_sel;
   logic [7:0]                        cpu_off;
   logic                              ctrl_en_q;
   logic [NUM_SRC-1:0]                en_vec;
   logic [NUM_SRC-1:0][NUM_CPU-1:0]   route;
   logic [NUM_CPU-1:0][IDX_W-1:0]     ack_ids;
   logic [NUM_CPU-1:0][THR_W-1:0]     thr_vals;
   logic [NUM_CPU-1:0]                thr_zero;
   logic [BUS_W-1:0]                  rd_next;
   logic                              unused_wdata;

   assign unused_wdata = ^bus_wdata[BUS_W-1:IDX_W];

   assign wr_acc   = bus_sel & bus_wr;
   assign rd_acc   = bus_sel & ~bus_wr;
   assign g_wr     = wr_acc & ~bus_cpu_win;
   assign wr_idx   = bus_wdata[IDX_W-1:0];
   assign word_hit = (bus_addr >= G_WORD_BASE) && (32'(bus_addr) < WORD_END)
                     && (bus_addr[1:0] == 2'b00);
   assign word_idx = SRC_W'((bus_addr - G_WORD_BASE) >> 2);
   assign cpu_sel  = bus_addr[ADDR_W-1:8];
   assign cpu_off  = bus_addr[7:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ctrl_en_q <= 1'b0;
      else if (g_wr && bus_addr == G_CTRL) ctrl_en_q <= bus_wdata[0];
   end

   idx_intc_route_bank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (g_wr && bus_addr == G_SET_EN),
      .clr_en    (g_wr && bus_addr == G_CLR_EN),
      .en_idx    (wr_idx),
      .word_wr   (g_wr && word_hit),
      .word_idx  (word_idx),
      .word_data (bus_wdata[NUM_CPU-1:0]),
      .en_o      (en_vec),
      .route_o   (route)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      cpu_cmd_t           cmd;
      logic               hit;
      logic [NUM_SRC-1:0] col;
      logic [NUM_SRC-1:0] pend;

      always_comb begin
         hit           = wr_acc && bus_cpu_win && (cpu_sel == CSEL_W'(c));
         cmd.mask_wr   = hit && (cpu_off == C_MASK);
         cmd.unmask_wr = hit && (cpu_off == C_UNMASK);
         cmd.thr_wr    = hit && (cpu_off == C_THR);
         cmd.idx       = wr_idx;
         cmd.thr       = bus_wdata[THR_W-1:0];
      end

      always_comb begin
         for (int s = 0; s < int'(NUM_SRC); s++) col[s] = route[s][c];
      end

      assign pend = {src_shared_i, src_priv_i[c*PRIV_SRC +: PRIV_SRC]};

      idx_intc_cpu_port #(.NUM_SRC(NUM_SRC)) u_port (
         .clk        (clk),
         .rst_n      (rst_n),
         .cmd        (cmd),
         .ctrl_en    (ctrl_en_q),
         .pend       (pend),
         .en         (en_vec),
         .route_col  (col),
         .irq_o      (irq_o[c]),
         .ack_id_o   (ack_ids[c]),
         .thr_o      (thr_vals[c]),
         .thr_zero_o (thr_zero[c])
      );
   end

   always_comb begin
      rd_next = '0;
      if (!bus_cpu_win) begin
         if (bus_addr == G_CTRL) begin
            rd_next[0]    = ctrl_en_q;
            rd_next[11:2] = IDX_W'(NUM_SRC);
         end else if (word_hit) begin
            rd_next[NUM_CPU-1:0] = route[word_idx];
         end
      end else begin
         for (int c = 0; c < int'(NUM_CPU); c++) begin
            if (cpu_sel == CSEL_W'(c)) begin
               case (cpu_off)
                  C_PEND:  rd_next[PRIV_SRC-1:0] = src_priv_i[c*PRIV_SRC +: PRIV_SRC];
                  C_THR:   rd_next[THR_W-1:0]    = thr_vals[c];
                  C_ACK:   rd_next[IDX_W-1:0]    = ack_ids[c];
                  default: rd_next               = '0;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_acc) bus_rdata <= rd_next;
   end
endmodule

// File: rtl/idx_intc_chk.sv
module idx_intc_chk
   import idx_intc_pkg::*;
#(
   parameter  int unsigned NUM_CPU = 4,
   parameter  int unsigned NUM_SRC = 64,
   localparam int unsigned SRC_W   = $clog2(NUM_SRC)
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_sel,
   input logic                    bus_wr,
   input logic                    bus_cpu_win,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [BUS_W-1:0]        bus_wdata,
   input logic [BUS_W-1:0]        bus_rdata,
   input logic [NUM_CPU-1:0]      irq,
   input logic                    ctrl_en,
   input logic [NUM_CPU-1:0]      thr_zero,
   input logic [NUM_CPU-1:0][IDX_W-1:0] ack_ids,
   input logic [NUM_SRC-1:0]      en_vec
);
   logic [SRC_W-1:0] last_idx;
   logic             set_ok;
   logic             unused_chk;

   assign unused_chk = ^bus_wdata[BUS_W-1:IDX_W];
   assign set_ok = bus_sel && bus_wr && !bus_cpu_win && bus_addr == G_SET_EN
                   && bus_wdata[IDX_W-1:0] >= IDX_W'(PRIV_SRC)
                   && bus_wdata[IDX_W-1:0] <  IDX_W'(NUM_SRC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_idx <= '0;
      else        last_idx <= bus_wdata[SRC_W-1:0];
   end

   // R6
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |=> irq == '0);

   // R3
   set_enable_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_ok |=> en_vec[last_idx]);

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      // R9
      thr_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !thr_zero[c] |=> !irq[c]);

      // R8
      irq_has_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq[c] |-> $past(ack_ids[c]) != NO_IRQ);

      // R8
      ack_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ack_ids[c] != NO_IRQ |-> ack_ids[c] < IDX_W'(NUM_SRC));
   end
endmodule

bind idx_intc idx_intc_chk #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_cpu_win (bus_cpu_win),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .irq         (irq_o),
   .ctrl_en     (ctrl_en_q),
   .thr_zero    (thr_zero),
   .ack_ids     (ack_ids),
   .en_vec      (en_vec)
);

// File: tb/sim_idx_intc.sv
`timescale 1ns/1ps
module sim_idx_intc;
   localparam int NCPU = 4;
   localparam int NSRC = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0, bus_wr = 1'b0, bus_cpu_win = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NSRC-33:0]  src_shared_i = '0;
   logic [NCPU*32-1:0] src_priv_i = '0;
   logic [NCPU-1:0]   irq_o;

   int checks = 0, failures = 0, cyc = 0;
   bit done = 0;

   typedef struct {
      int          kind;   // 0 = read data, 1 = irq lines
      logic [31:0] exp;
      int          due;
      string       tag;
   } sb_item_t;
   sb_item_t sb[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   idx_intc #(.NUM_CPU(NCPU), .NUM_SRC(NSRC)) u0 (
      .clk, .rst_n, .bus_sel, .bus_wr, .bus_cpu_win, .bus_addr,
      .bus_wdata, .bus_rdata, .src_shared_i, .src_priv_i, .irq_o
   );

   // monitor: pops every item whose sampling cycle has arrived
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         sb_item_t it;
         logic [31:0] act;
         it  = sb.pop_front();
         act = (it.kind == 0) ? bus_rdata : 32'(irq_o);
         checks++;
         if (act !== it.exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic push(input int k, input logic [31:0] e, input string tag);
      sb_item_t it;
      it.kind = k; it.exp = e; it.due = cyc + 1; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic wr(input logic win, input logic [11:0] a, input logic [31:0] d);
      bus_sel = 1; bus_wr = 1; bus_cpu_win = win; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic win, input logic [11:0] a, input logic [31:0] e,
                     input string tag);
      bus_sel = 1; bus_wr = 0; bus_cpu_win = win; bus_addr = a;
      push(0, e, tag);
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic exp_irq(input logic [3:0] e, input string tag);
      push(1, 32'(e), tag);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // reset state
      rd(0, 12'h000, 32'h100, "R1 ctrl after reset");
      exp_irq(4'h0, "R1 irq after reset");
      rd(1, 12'h044, 32'h3ff, "R1 ack after reset");
      rd(1, 12'h140, 32'h0, "R1 threshold after reset");
      rd(0, 12'h1A0, 32'h0, "R1 route after reset");

      // control register
      wr(0, 12'h000, 32'hFFFF_FFFF);
      rd(0, 12'h000, 32'h101, "R2 ctrl only bit0 writable");

      // routing words
      wr(0, 12'h1A0, 32'hFFFF_FFFF);
      rd(0, 12'h1A0, 32'hF, "R5 route src40");
      wr(0, 12'h114, 32'h2);
      rd(0, 12'h114, 32'h2, "R5 route src5");

      // shared source 40
      src_shared_i[8] = 1'b1;
      exp_irq(4'h0, "R3 pending but not enabled");
      rd(1, 12'h044, 32'h3ff, "R8 nothing deliverable");
      wr(0, 12'h030, 32'h0000_FC28);
      exp_irq(4'hF, "R3 set-enable uses bits 9:0, R6 all routed");
      rd(1, 12'h244, 32'd40, "R8 ack cpu2 = 40");
      wr(0, 12'h034, 32'd40);
      exp_irq(4'h0, "R3 clear-enable");

      // private source 5 on processor 1
      src_priv_i[37] = 1'b1;
      wr(0, 12'h030, 32'd5);
      exp_irq(4'h0, "R3 private index ignored, R4 reset masked");
      rd(1, 12'h110, 32'h20, "R7 cause cpu1");
      rd(1, 12'h010, 32'h0, "R7 cause cpu0");
      wr(1, 12'h04C, 32'd5);
      exp_irq(4'h0, "R4 unmask on cpu0 leaves cpu1 masked");
      wr(1, 12'h14C, 32'd5);
      exp_irq(4'h2, "R4 unmask cpu1");
      rd(1, 12'h144, 32'd5, "R8 ack cpu1 = 5");
      rd(1, 12'h044, 32'h3ff, "R8 ack cpu0 none");
      wr(1, 12'h148, 32'd5);
      exp_irq(4'h0, "R4 mask cpu1");

      // lowest-number selection
      wr(1, 12'h14C, 32'd5);
      wr(0, 12'h184, 32'h2);
      src_shared_i[1] = 1'b1;
      wr(0, 12'h030, 32'd33);
      exp_irq(4'h2, "R6 only cpu1 routed");
      rd(1, 12'h144, 32'd5, "R8 lowest of 5,33");
      wr(0, 12'h030, 32'd40);
      exp_irq(4'hF, "R6 src40 re-enabled");
      rd(1, 12'h044, 32'd40, "R8 cpu0 sees 40");
      src_priv_i[37] = 1'b0;
      rd(1, 12'h144, 32'd33, "R8 lowest of 33,40");

      // threshold
      wr(1, 12'h240, 32'd3);
      rd(1, 12'h240, 32'd3, "R9 threshold readback");
      exp_irq(4'hB, "R9 non-zero threshold blocks cpu2");
      rd(1, 12'h244, 32'h3ff, "R9 ack blocked");
      wr(1, 12'h240, 32'd0);
      exp_irq(4'hF, "R9 threshold zero reopens");

      // controller enable off
      wr(0, 12'h000, 32'h0);
      exp_irq(4'h0, "R6 controller disabled");
      rd(1, 12'h144, 32'h3ff, "R6 ack with controller off");

      // absent processor and read timing
      wr(1, 12'h540, 32'd7);
      rd(1, 12'h540, 32'h0, "R10 absent processor reads 0");
      rd(1, 12'h340, 32'h0, "R10 cpu3 threshold untouched");
      rd(0, 12'h1A0, 32'hF, "R10 read lands next cycle");
      push(0, 32'hF, "R10 rdata holds without read");
      @(negedge clk);

      repeat (3) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule